// File: doc/BRIEF.md
# ATA Device Task-File Status Logic

This block is the device-side register logic of a parallel ATA style drive. A host reaches it over a small bus with a 3-bit register offset, a read strobe, a write strobe and an 8-bit write data path. The block holds the status byte and the device/head byte. It drives the host interrupt line. It decides what each host read returns. An internal command engine feeds it with these signals:
- a start pulse;
- a completion pulse that carries error and data-request flags;
- a live drive-ready level;
- the nibble of the disk address that is currently selected.

A status read also acknowledges the interrupt. While the busy bit is set, every register offset returns the status byte, and host writes are dropped. After a command ends in error, the drive-ready bit is frozen until the host reads status. The block hands each accepted command byte to the engine as a single-cycle strobe. It exposes the device/head byte so the engine can see the addressing mode (bit 6, 1 = LBA) and the head or LBA bits 27:24 (bits 3:0).

Top module: `ata_tf_status`

## Requirements
- R1: After a synchronous active-low reset, the status byte is 0x00, the interrupt is low and the device/head byte is 0x00.
- R2: The status byte carries busy at bit 7, drive-ready at bit 6, data-request at bit 3 and error at bit 0. Bits 5, 4, 2 and 1 always read 0.
- R3: A host write to offset 7 while not busy pulses cmd_valid in that same cycle, with cmd_byte equal to the write data. From the next cycle, busy is 1 and error and data-request are 0. An engine start pulse has the same effect on the status bits.
- R4: While busy is 1, a read at any offset 0 to 7 returns the status byte.
- R5: While busy is 1, host writes are ignored: no cmd_valid is produced, and the device/head byte does not change.
- R6: A completion pulse has these effects on the next cycle: busy is 0, error equals eng_err, data-request equals eng_drq, the interrupt is 1, and device/head bits 3:0 equal eng_addr_nib while bits 7:4 keep their value.
- R7: Once raised, the interrupt stays high until a host read at offset 7. It is then low from the next cycle. Reads at other offsets leave it unchanged.
- R8: Outside an error freeze, the drive-ready bit equals the eng_ready level of the previous cycle. It is therefore 0 after reset until the engine reports ready.
- R9: A completion with eng_err=1 freezes drive-ready at its value before that completion. The freeze lasts until a host read at offset 7. On the edge of that read, drive-ready samples eng_ready again.
- R10: While not busy, offset 7 reads the status byte, offset 6 reads the device/head byte, and offsets 0 to 5 read 0x00.
- R11: A host write to offset 6 while not busy stores the whole byte into device/head from the next cycle. Bit 6 selects LBA addressing when 1; bits 3:0 hold the head number or LBA bits 27:24.
- R12: If a completion and a status read fall in the same cycle, the interrupt is 1 on the next cycle (setting wins over acknowledge).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 3 | Register offset on the host bus |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for the presented offset (combinational) |
| host_irq | output | 1 | Interrupt request to the host |
| eng_start | input | 1 | Engine-initiated start pulse |
| eng_done | input | 1 | Command completion pulse |
| eng_err | input | 1 | Error result, valid with eng_done |
| eng_drq | input | 1 | Data-request result, valid with eng_done |
| eng_ready | input | 1 | Live drive-ready level |
| eng_addr_nib | input | 4 | Currently selected head / LBA 27:24 nibble |
| cmd_valid | output | 1 | Accepted command write strobe |
| cmd_byte | output | 8 | Command byte, valid with cmd_valid |
| devhead_q | output | 8 | Current device/head byte |

## Verification
The bench covers the following corner cases, each with the symptom a wrong design would show:
- **Frozen drive-ready.** The bench drops eng_ready at the same moment as an error completion. A design that does not freeze would show drive-ready low on the acknowledging read instead of high. A design that never unfreezes would keep it high afterwards.
- **Reads while busy.** The bench reads offsets other than 7 during busy. A mux without the busy override would return 0x00 or the device/head byte.
- **Writes while busy.** Writes during busy would otherwise corrupt device/head or start a second command.
- **Completion coinciding with acknowledge.** A wrong priority would lose the new interrupt.
- **Randomized sweep.** Every offset, strobe and engine event is combined, and the bench compares every cycle against an arithmetic model.

// File: rtl/tfs_pkg.sv
// Shared types and bit positions for the task-file status logic.
// Assumes an 8-bit host data path; the status layout is fixed by the host protocol.
package tfs_pkg;

    localparam int ST_W        = 8;
    localparam int ST_BUSY_POS = 7;
    localparam int ST_DRDY_POS = 6;
    localparam int ST_DRQ_POS  = 3;
    localparam int ST_ERR_POS  = 0;

    typedef struct packed {
        logic busy;
        logic drdy;
        logic drq;
        logic err;
    } tfs_status_t;

    // Place the four live status bits into the host-visible byte; others are zero.
    function automatic logic [ST_W-1:0] tfs_pack(input tfs_status_t s);
        logic [ST_W-1:0] b;
        b              = '0;
        b[ST_BUSY_POS] = s.busy;
        b[ST_DRDY_POS] = s.drdy;
        b[ST_DRQ_POS]  = s.drq;
        b[ST_ERR_POS]  = s.err;
        return b;
    endfunction

endpackage

// File: rtl/tfs_status_core.sv
// Status core: holds busy, error, data-request and drive-ready, plus the
// error freeze that pins drive-ready until the host reads status.
// Assumes the engine pulses done only while busy and start only while idle.
module tfs_status_core
    import tfs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_start,
    input  logic        done,
    input  logic        eng_err,
    input  logic        eng_drq,
    input  logic        eng_ready,
    input  logic        stat_rd,
    output tfs_status_t st
);

    logic busy_q, err_q, drq_q, drdy_q, freeze_q;
    logic err_done;
    logic hold_drdy;

    assign err_done  = done & eng_err;
    assign hold_drdy = err_done | (freeze_q & ~stat_rd);

    // Busy: set by any command start, cleared by completion; start wins.
    always_ff @(posedge clk) begin
        if (!rst_n)         busy_q <= 1'b0;
        else if (cmd_start) busy_q <= 1'b1;
        else if (done)      busy_q <= 1'b0;
    end

    // Error and data-request: cleared on start, loaded from the engine on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
            drq_q <= 1'b0;
        end else if (cmd_start) begin
            err_q <= 1'b0;
            drq_q <= 1'b0;
        end else if (done) begin
            err_q <= eng_err;
            drq_q <= eng_drq;
        end
    end

    // Freeze flag: armed by an error completion, released by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n)        freeze_q <= 1'b0;
        else if (err_done) freeze_q <= 1'b1;
        else if (stat_rd)  freeze_q <= 1'b0;
    end

    // Drive-ready: tracks the engine level unless frozen.
    always_ff @(posedge clk) begin
        if (!rst_n)          drdy_q <= 1'b0;
        else if (!hold_drdy) drdy_q <= eng_ready;
    end

    assign st = '{busy: busy_q, drdy: drdy_q, drq: drq_q, err: err_q};

    assert_start_sets_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && cmd_start) |-> (busy_q && !err_q && !drq_q));

    assert_done_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && done && !cmd_start) |-> (!busy_q && err_q == $past(eng_err) && drq_q == $past(eng_drq)));

    assert_drdy_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !freeze_q && !(done && eng_err)) |-> (drdy_q == $past(eng_ready)));

    assert_drdy_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && freeze_q && !stat_rd) |-> $stable(drdy_q));

endmodule

// File: rtl/tfs_irq_ctl.sv
// Interrupt controller: raises the host interrupt on completion and drops it
// when the host reads status. Completion has priority over acknowledge.
module tfs_irq_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic done,
    input  logic stat_rd,
    output logic irq
);

    logic irq_q;

    // Pending interrupt flag with set-over-clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq_q <= 1'b0;
        else if (done)    irq_q <= 1'b1;
        else if (stat_rd) irq_q <= 1'b0;
    end

    assign irq = irq_q;

    assert_irq_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && stat_rd && !done) |-> !irq_q);

    assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && irq_q && !stat_rd) |-> irq_q);

    assert_irq_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && done) |-> irq_q);

endmodule

// File: rtl/tfs_devhead_reg.sv
// Device/head register: host-written byte whose low nibble is replaced by the
// engine's selected address nibble at each completion.
// Assumes host writes reach here already gated by busy.
module tfs_devhead_reg #(
    parameter int DW    = 8,
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DW-1:0]    wdata,
    input  logic             done,
    input  logic [NIB_W-1:0] addr_nib,
    output logic [DW-1:0]    dh
);

    logic [DW-1:0] dh_q;

    // Host write loads the whole byte; completion refreshes the low nibble.
    always_ff @(posedge clk) begin
        if (!rst_n)     dh_q <= '0;
        else if (wr_en) dh_q <= wdata;
        else if (done)  dh_q <= {dh_q[DW-1:NIB_W], addr_nib};
    end

    assign dh = dh_q;

    assert_dh_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && wr_en) |-> (dh_q == $past(wdata)));

    assert_dh_refresh_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && done && !wr_en) |->
            (dh_q[NIB_W-1:0] == $past(addr_nib) && dh_q[DW-1:NIB_W] == $past(dh_q[DW-1:NIB_W])));

endmodule

// File: rtl/tfs_host_port.sv
// Host port: decodes strobes into command, device/head write and status-read
// events, and selects the read data. Busy overrides every offset with status.
module tfs_host_port #(
    parameter int AW       = 3,
    parameter int DW       = 8,
    parameter int STAT_OFS = 7,
    parameter int DH_OFS   = 6
) (
    input  logic          rst_n,
    input  logic          clk,
    input  logic [AW-1:0] addr,
    input  logic          rd,
    input  logic          wr,
    input  logic          busy,
    input  logic [DW-1:0] status_byte,
    input  logic [DW-1:0] dh,
    output logic          stat_rd,
    output logic          cmd_wr,
    output logic          dh_wr,
    output logic [DW-1:0] rdata
);

    localparam int NREG = 1 << AW;

    logic [DW-1:0] lane [NREG];

    // One lane per offset: status, device/head, or zero for registers held elsewhere.
    for (genvar i = 0; i < NREG; i++) begin : g_lane
        if (i == STAT_OFS) begin : g_st
            assign lane[i] = status_byte;
        end else if (i == DH_OFS) begin : g_dh
            assign lane[i] = dh;
        end else begin : g_zero
            assign lane[i] = '0;
        end
    end

    // Strobe decode; writes are gated by busy, status reads are not.
    always_comb begin
        stat_rd = rd & (addr == AW'(STAT_OFS));
        cmd_wr  = wr & ~busy & (addr == AW'(STAT_OFS));
        dh_wr   = wr & ~busy & (addr == AW'(DH_OFS));
    end

    // Read data select with busy override.
    always_comb begin
        if (busy) rdata = status_byte;
        else      rdata = lane[addr];
    end

    assert_busy_blocks_writes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!cmd_wr && !dh_wr));

    assert_busy_reads_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rdata == status_byte));

endmodule

// File: rtl/ata_tf_status.sv
// Top of the task-file status logic: ties the host port, status core,
// interrupt controller and device/head register together.
// Assumes eng_done pulses only while busy and eng_start only while idle.
module ata_tf_status
    import tfs_pkg::*;
#(
    parameter int AW       = 3,
    parameter int DW       = 8,
    parameter int NIB_W    = 4,
    parameter int STAT_OFS = 7,
    parameter int DH_OFS   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    host_addr,
    input  logic             host_rd,
    input  logic             host_wr,
    input  logic [DW-1:0]    host_wdata,
    output logic [DW-1:0]    host_rdata,
    output logic             host_irq,
    input  logic             eng_start,
    input  logic             eng_done,
    input  logic             eng_err,
    input  logic             eng_drq,
    input  logic             eng_ready,
    input  logic [NIB_W-1:0] eng_addr_nib,
    output logic             cmd_valid,
    output logic [DW-1:0]    cmd_byte,
    output logic [DW-1:0]    devhead_q
);

    tfs_status_t   st;
    logic [DW-1:0] status_byte;
    logic [DW-1:0] dh;
    logic          stat_rd, cmd_wr, dh_wr, any_start;

    assign status_byte = DW'(tfs_pack(st));
    assign any_start   = cmd_wr | eng_start;

    tfs_host_port #(.AW(AW), .DW(DW), .STAT_OFS(STAT_OFS), .DH_OFS(DH_OFS)) u_port (
        .rst_n(rst_n), .clk(clk), .addr(host_addr), .rd(host_rd), .wr(host_wr),
        .busy(st.busy), .status_byte(status_byte), .dh(dh),
        .stat_rd(stat_rd), .cmd_wr(cmd_wr), .dh_wr(dh_wr), .rdata(host_rdata)
    );

    tfs_status_core u_core (
        .clk(clk), .rst_n(rst_n), .cmd_start(any_start), .done(eng_done),
        .eng_err(eng_err), .eng_drq(eng_drq), .eng_ready(eng_ready),
        .stat_rd(stat_rd), .st(st)
    );

    tfs_irq_ctl u_irq (
        .clk(clk), .rst_n(rst_n), .done(eng_done), .stat_rd(stat_rd), .irq(host_irq)
    );

    tfs_devhead_reg #(.DW(DW), .NIB_W(NIB_W)) u_dh (
        .clk(clk), .rst_n(rst_n), .wr_en(dh_wr), .wdata(host_wdata),
        .done(eng_done), .addr_nib(eng_addr_nib), .dh(dh)
    );

    assign cmd_valid = cmd_wr;
    assign cmd_byte  = host_wdata;
    assign devhead_q = dh;

    assert_obsolete_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st.busy || host_addr == AW'(STAT_OFS)) |->
            (host_rdata[5:4] == 2'b00 && host_rdata[2:1] == 2'b00));

    assert_reset_state_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> (!host_irq && !st.busy && !st.drdy && !st.err && dh == '0));

endmodule

// File: tb/tb_ata_tf_status.sv
// Bench: directed corner cases followed by a long randomized sweep, each cycle
// compared against an arithmetic model of the requirements.
module tb_ata_tf_status;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] host_addr;
    logic       host_rd, host_wr;
    logic [7:0] host_wdata;
    logic [7:0] host_rdata;
    logic       host_irq;
    logic       eng_start, eng_done, eng_err, eng_drq, eng_ready;
    logic [3:0] eng_addr_nib;
    logic       cmd_valid;
    logic [7:0] cmd_byte;
    logic [7:0] devhead_q;

    int n_chk  = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;

    // Reference model state
    bit       m_busy, m_drdy, m_err, m_drq, m_frz, m_irq;
    bit [7:0] m_dh;

    always #10 clk = ~clk;

    ata_tf_status dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_irq(host_irq), .eng_start(eng_start), .eng_done(eng_done),
        .eng_err(eng_err), .eng_drq(eng_drq), .eng_ready(eng_ready),
        .eng_addr_nib(eng_addr_nib), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .devhead_q(devhead_q)
    );

    function automatic bit [7:0] m_status();
        return {m_busy, m_drdy, 2'b00, m_drq, 2'b00, m_err};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%02h expected=%02h at %0t", req, act, exp, $time);
        end
    endtask

    // One bus cycle: drive at negedge, check combinational outputs, clock, update model, check state.
    task automatic cyc(input bit rd, input bit wr, input bit [2:0] a, input bit [7:0] wd,
                       input bit st, input bit dn, input bit er, input bit dq, input bit [3:0] nib);
        bit [7:0] exp_rd;
        bit stat_rd, cmdw, dhw, start, ed;
        host_rd = rd; host_wr = wr; host_addr = a; host_wdata = wd;
        eng_start = st; eng_done = dn; eng_err = er; eng_drq = dq; eng_addr_nib = nib;
        #1;
        if (m_busy)        begin exp_rd = m_status(); chk("R4", host_rdata, exp_rd); end
        else if (a == 3'd7) begin exp_rd = m_status(); chk("R2", host_rdata, exp_rd); end
        else if (a == 3'd6) begin exp_rd = m_dh;       chk("R10", host_rdata, exp_rd); end
        else               begin exp_rd = 8'h00;      chk("R10", host_rdata, exp_rd); end
        cmdw = wr && a == 3'd7 && !m_busy;
        dhw  = wr && a == 3'd6 && !m_busy;
        if (m_busy && wr) chk("R5", {7'd0, cmd_valid}, 8'h00);
        else begin
            chk("R3", {7'd0, cmd_valid}, {7'd0, cmdw});
            if (cmdw) chk("R3", cmd_byte, wd);
        end
        stat_rd = rd && a == 3'd7;
        start   = cmdw || st;
        ed      = dn && er;
        @(posedge clk);
        if (!(ed || (m_frz && !stat_rd))) m_drdy = eng_ready;
        if (ed) m_frz = 1'b1; else if (stat_rd) m_frz = 1'b0;
        if (start) begin m_busy = 1; m_err = 0; m_drq = 0; end
        else if (dn) begin m_busy = 0; m_err = er; m_drq = dq; end
        if (dn) m_irq = 1'b1; else if (stat_rd) m_irq = 1'b0;
        if (dhw) m_dh = wd; else if (dn) m_dh = {m_dh[7:4], nib};
        @(negedge clk);
        chk("R7", {7'd0, host_irq}, {7'd0, m_irq});
        chk("R11", devhead_q, m_dh);
    endtask

    task automatic idle();
        cyc(0, 0, 3'd0, 8'h00, 0, 0, 0, 0, 4'h0);
    endtask

    // Combinational read of an offset without a clock edge.
    task automatic peek(input bit [2:0] a, output logic [7:0] v);
        host_rd = 0; host_wr = 0; host_addr = a; #1; v = host_rdata;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        rst_n = 0; host_rd = 0; host_wr = 0; host_addr = 0; host_wdata = 0;
        eng_start = 0; eng_done = 0; eng_err = 0; eng_drq = 0; eng_ready = 1; eng_addr_nib = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        m_busy = 0; m_drdy = 0; m_err = 0; m_drq = 0; m_frz = 0; m_irq = 0; m_dh = 0;

        // R1: reset state (eng_ready was high during reset, still 0 here)
        peek(3'd7, v); chk("R1", v, 8'h00);
        chk("R1", {7'd0, host_irq}, 8'h00);
        chk("R1", devhead_q, 8'h00);

        // R8: drive-ready follows the engine one cycle later
        eng_ready = 0; idle(); peek(3'd7, v); chk("R8", v, 8'h00);
        eng_ready = 1; idle(); peek(3'd7, v); chk("R8", v, 8'h40);

        // R11: device/head write; LBA bit 6 and nibble stored
        cyc(0, 1, 3'd6, 8'hE5, 0, 0, 0, 0, 4'h0);
        peek(3'd6, v); chk("R11", v, 8'hE5);

        // R3: command write
        cyc(0, 1, 3'd7, 8'h20, 0, 0, 0, 0, 4'h0);
        peek(3'd7, v); chk("R3", v, 8'hC0);
        // R4: other offsets return status while busy
        for (int a = 0; a < 7; a++) begin peek(3'(a), v); chk("R4", v, 8'hC0); end
        // R5: writes while busy ignored
        cyc(0, 1, 3'd6, 8'h11, 0, 0, 0, 0, 4'h0);
        cyc(0, 1, 3'd7, 8'h30, 0, 0, 0, 0, 4'h0);
        chk("R5", devhead_q, 8'hE5);

        // R6/R9: error completion with ready dropping at the same time
        eng_ready = 0;
        cyc(0, 0, 3'd0, 8'h00, 0, 1, 1, 0, 4'hA);
        chk("R6", devhead_q, 8'hEA);
        chk("R6", {7'd0, host_irq}, 8'h01);
        cyc(1, 0, 3'd5, 8'h00, 0, 0, 0, 0, 4'h0);
        chk("R7", {7'd0, host_irq}, 8'h01);
        peek(3'd7, v); chk("R9", v, 8'h41);
        cyc(1, 0, 3'd7, 8'h00, 0, 0, 0, 0, 4'h0);
        chk("R7", {7'd0, host_irq}, 8'h00);
        peek(3'd7, v); chk("R9", v, 8'h01);

        // R12: completion coinciding with a status read
        eng_ready = 1;
        cyc(0, 1, 3'd7, 8'hC8, 0, 0, 0, 0, 4'h0);
        cyc(1, 0, 3'd7, 8'h00, 0, 1, 0, 1, 4'h3);
        chk("R12", {7'd0, host_irq}, 8'h01);
        peek(3'd7, v); chk("R6", v, 8'h48);

        // Randomized sweep over all offsets, strobes and engine events
        for (int i = 0; i < 4000; i++) begin
            bit [31:0] r;
            bit st, dn;
            r = $urandom;
            eng_ready = r[20] | r[21];
            st = !m_busy && (r[24:22] == 3'd0);
            dn = m_busy && (r[27:25] < 3'd3);
            cyc(r[0], r[1], r[4:2], r[12:5], st, dn, r[13], r[14], r[18:15]);
        end

        done_flag = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule